// File: doc/BRIEF.md
# Prescaled Time-Stamp Timer with Drift Trim

This block is a free-running time-stamp counter for a CAN-style controller. A single-cycle source-clock enable feeds a programmable divider, and each divider terminal count advances the counter by one. A six-bit divider code of zero lets every enable pulse through. Any other code N passes one pulse in every 2×N.

A trim unit nudges the counter against an outside reference. It counts timer ticks, not enable pulses. On every P-th tick, where P is the value in the period register, it replaces the normal +1 step with a correction step. A mode bit picks the correction step: +0 holds the count for that tick, and +2 skips one value ahead. A period of zero turns trimming off.

Software uses one write port to reach two registers. The control byte holds the mode bit at bit 7, a reserved bit at bit 6 and the divider code at bits 5:0. The 16-bit period register is the second. The counter value and the control byte are plain read outputs. No handshake is involved: a write lands on the clock edge where `wr_en` is high.

Top module: `drift_timer`

## Requirements
- R1: With divider code 0, the counter ticks on every cycle where `src_en` is high, and it never changes in a cycle where `src_en` is low.
- R2: With a nonzero divider code N, one tick happens in every 2×N `src_en` pulses, so code 63 divides by 126.
- R3: A new divider code takes effect only after the terminal count of the division already in progress. After reset the first division is by 1.
- R4: A tick without correction adds 1 to `count_o`, and 0xFFFF wraps to 0x0000.
- R5: When the period register P is nonzero, every P-th tick is a correction tick. The trim count advances only on ticks.
- R6: When the mode bit (control bit 7) is 0, a correction tick leaves `count_o` unchanged.
- R7: When the mode bit is 1, a correction tick adds 2 modulo 2^16, so 0xFFFF becomes 0x0001 and 0xFFFE becomes 0x0000.
- R8: A period of 0 disables correction, and every tick adds exactly 1.
- R9: A write to the period register restarts the trim count, so the next correction falls on the P-th tick after the write.
- R10: `count_o` and the control register reset to 0. A write with `wr_sel`=0 stores data bits 7 and 5:0 in the control register. Bit 6 is reserved and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | 1 | Source-clock enable, one cycle per source pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = period register |
| wr_data | input | 16 | Write data (the control write uses bits 7:0) |
| ctrl_rdata | output | 8 | Control register readback |
| count_o | output | 16 | Timer value |

## Verification
On every cycle, the in-RTL assertions check the step rules: a hold without a tick, +1 on a plain tick, and +0 or +2 on a correction tick. They also check that the divider and trim counters stay below their limits, and that a disabled period gives plain +1 steps. What the assertions cannot show is spacing across many cycles. The bench scenarios cover that: the number of enable pulses between ticks for each divider code, a code change that waits for the current terminal count, correction every P-th tick and its restart after a period write, and both wrap points of the +1 and +2 steps.

// File: rtl/dt_pkg.sv
package dt_pkg;
  typedef enum logic {
    TRIM_HOLD = 1'b0,
    TRIM_SKIP = 1'b1
  } trim_mode_e;

  typedef enum logic {
    SEL_CTRL   = 1'b0,
    SEL_PERIOD = 1'b1
  } wr_target_e;
endpackage

// File: rtl/dt_prescaler.sv
module dt_prescaler #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_en,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  localparam int LIM_W = CODE_W + 1;

  logic [LIM_W-1:0] lim_q;
  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W-1:0] lim_next;
  logic             terminal;

  // code 0 -> divide by 1, code N -> divide by 2N
  assign lim_next = (code_i == '0) ? LIM_W'(1) : {code_i, 1'b0};
  assign terminal = (cnt_q == lim_q - LIM_W'(1));
  assign tick_o   = src_en & terminal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= LIM_W'(1);
      cnt_q <= '0;
    end else if (src_en) begin
      if (terminal) begin
        cnt_q <= '0;
        lim_q <= lim_next;   // R3: new code adopted only at terminal count
      end else begin
        cnt_q <= cnt_q + LIM_W'(1);
      end
    end
  end

  assert_div_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < lim_q);
  assert_div_even_or_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_q == LIM_W'(1)) || !lim_q[0]);
  assert_div_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !src_en |=> $stable(cnt_q));
endmodule

// File: rtl/dt_drift.sv
module dt_drift #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                period_wr_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                corr_o
);
  logic [PERIOD_W-1:0] trim_q;
  logic                active;
  logic                hit;

  assign active = |period_i;
  assign hit    = active && (trim_q == period_i - PERIOD_W'(1));
  assign corr_o = tick_i & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_q <= '0;
    end else if (period_wr_i) begin
      trim_q <= '0;                       // R9
    end else if (tick_i && active) begin
      trim_q <= hit ? '0 : trim_q + PERIOD_W'(1);
    end
  end

  assert_trim_below_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (trim_q < period_i));
  assert_trim_only_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !period_wr_i) |=> $stable(trim_q));
endmodule

// File: rtl/dt_counter.sv
module dt_counter
  import dt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             corr_i,
  input  trim_mode_e       mode_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] step;

  always_comb begin
    if (!corr_i)                 step = CNT_W'(1);
    else if (mode_i == TRIM_SKIP) step = CNT_W'(2);
    else                         step = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (tick_i) count_q <= count_q + step;
  end

  assign count_o = count_q;

  assert_no_tick_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(count_q));
  assert_plain_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !corr_i) |=> (count_q == $past(count_q) + CNT_W'(1)));
  assert_hold_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && corr_i && mode_i == TRIM_HOLD) |=> $stable(count_q));
  assert_skip_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && corr_i && mode_i == TRIM_SKIP) |=> (count_q == $past(count_q) + CNT_W'(2)));
endmodule

// File: rtl/drift_timer.sv
module drift_timer
  import dt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PERIOD_W = 16,
  parameter int CODE_W   = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    src_en,
  input  logic                    wr_en,
  input  logic                    wr_sel,
  input  logic [PERIOD_W-1:0]     wr_data,
  output logic [CODE_W+1:0]       ctrl_rdata,
  output logic [CNT_W-1:0]        count_o
);
  localparam int CTRL_W   = CODE_W + 2;
  localparam int MODE_BIT = CODE_W + 1;
  localparam int RSVD_BIT = CODE_W;

  logic [CTRL_W-1:0]   ctrl_q;
  logic [PERIOD_W-1:0] period_q;
  logic                tick;
  logic                corr;
  logic                ctrl_wr;
  logic                period_wr;
  trim_mode_e          mode;

  assign ctrl_wr   = wr_en && (wr_target_e'(wr_sel) == SEL_CTRL);
  assign period_wr = wr_en && (wr_target_e'(wr_sel) == SEL_PERIOD);
  assign mode      = trim_mode_e'(ctrl_q[MODE_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q[MODE_BIT]     <= wr_data[MODE_BIT];
        ctrl_q[RSVD_BIT]     <= 1'b0;          // R10: reserved bit not stored
        ctrl_q[CODE_W-1:0]   <= wr_data[CODE_W-1:0];
      end
      if (period_wr) period_q <= wr_data;
    end
  end

  dt_prescaler #(.CODE_W(CODE_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_en (src_en),
    .code_i (ctrl_q[CODE_W-1:0]),
    .tick_o (tick)
  );

  dt_drift #(.PERIOD_W(PERIOD_W)) u_drift (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .period_wr_i (period_wr),
    .period_i    (period_q),
    .corr_o      (corr)
  );

  dt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .corr_i  (corr),
    .mode_i  (mode),
    .count_o (count_o)
  );

  assign ctrl_rdata = ctrl_q;

  assert_trim_off_plain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && period_q == '0) |=> (count_o == $past(count_o) + CNT_W'(1)));
  assert_tick_needs_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !src_en |=> $stable(count_o));
endmodule

// File: tb/drift_timer_bench.sv
module drift_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        src_en, wr_en, wr_sel;
  logic [15:0] wr_data;
  logic [7:0]  ctrl_rdata;
  logic [15:0] count_o;

  always #10 clk = ~clk;   // 50 MHz

  drift_timer u_drift_timer (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ctrl_rdata(ctrl_rdata), .count_o(count_o)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string tag   = "R10";

  // reference state
  int          e_pre, e_lim, e_trim;
  logic [7:0]  e_ctrl;
  logic [15:0] e_per, e_count;

  function automatic int lim_of(logic [5:0] c);
    return (c == 6'd0) ? 1 : 2 * int'(c);
  endfunction

  function automatic logic [15:0] step_of(bit corr, bit mode);
    if (!corr) return 16'd1;
    return mode ? 16'd2 : 16'd0;
  endfunction

  task automatic check();
    n_vec++;
    if (count_o !== e_count || ctrl_rdata !== e_ctrl) begin
      n_bad++;
      $display("FAIL %s: count %h ctrl %h, expected count %h ctrl %h",
               tag, count_o, ctrl_rdata, e_count, e_ctrl);
    end
  endtask

  task automatic apply(bit s, bit we, bit sel, logic [15:0] d);
    bit tk, cr;
    src_en = s; wr_en = we; wr_sel = sel; wr_data = d;
    tk = s && (e_pre == e_lim - 1);
    cr = tk && (e_per != 16'd0) && (e_trim == int'(e_per) - 1);
    if (tk) e_count = e_count + step_of(cr, e_ctrl[7]);
    if (s) begin
      if (tk) begin e_pre = 0; e_lim = lim_of(e_ctrl[5:0]); end
      else e_pre++;
    end
    if (we && sel) e_trim = 0;
    else if (tk && e_per != 16'd0) e_trim = cr ? 0 : e_trim + 1;
    if (we) begin
      if (sel) e_per = d;
      else     e_ctrl = {d[7], 1'b0, d[5:0]};
    end
    @(posedge clk);
    @(negedge clk);
    check();
  endtask

  task automatic run(int n, bit s);
    for (int i = 0; i < n; i++) apply(s, 1'b0, 1'b0, 16'h0);
  endtask

  initial begin
    #(20 * 190000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; src_en = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
    e_pre = 0; e_lim = 1; e_trim = 0; e_ctrl = '0; e_per = '0; e_count = '0;
    repeat (3) @(negedge clk);
    tag = "R10"; check();                 // reset values
    rst_n = 1'b1;

    // R10: reserved bit drops, other bits stored
    tag = "R10"; apply(0, 1, 0, 16'h00FF);
    apply(0, 1, 0, 16'h0040);
    apply(0, 1, 0, 16'h0000);

    // R1: code 0, sparse enables, no trimming
    tag = "R1";
    for (int i = 0; i < 60; i++) apply($urandom_range(0, 1), 0, 0, 0);

    // R2: code 63 divides by 126; R3: switch code mid-division
    tag = "R2"; apply(0, 1, 0, 16'h003F); run(300, 1);
    tag = "R3"; run(40, 1); apply(1, 1, 0, 16'h0002); run(120, 1);
    tag = "R2"; apply(0, 1, 0, 16'h0005); run(60, 1);

    // R6: hold correction every 3rd tick
    tag = "R6"; apply(0, 1, 0, 16'h0000); apply(0, 1, 1, 16'd3); run(30, 1);
    // R5: correction spacing across enable gaps
    tag = "R5";
    for (int i = 0; i < 60; i++) apply($urandom_range(0, 1), 0, 0, 0);
    // R7: +2 correction every 4th tick
    tag = "R7"; apply(0, 1, 0, 16'h0080); apply(0, 1, 1, 16'd4); run(30, 1);
    // R9: rewrite period mid-interval restarts trim count
    tag = "R9"; run(2, 1); apply(1, 1, 1, 16'd4); run(12, 1);
    apply(0, 1, 1, 16'd2); run(8, 1);
    // R8: period 0 disables trimming in both modes
    tag = "R8"; apply(0, 1, 1, 16'd0); run(20, 1);
    apply(0, 1, 0, 16'h0000); run(20, 1);

    // R4: +1 wrap. Fast-forward with +2 every tick
    tag = "R4";
    apply(0, 1, 0, 16'h0080); apply(0, 1, 1, 16'd1);
    while (e_count < 16'hFFF0) apply(1, 0, 0, 0);
    apply(0, 1, 1, 16'd0);
    while (e_count != 16'hFFFF) apply(1, 0, 0, 0);
    apply(1, 0, 0, 0);                    // FFFF -> 0000
    if (e_count != 16'h0000) $display("bench sequencing error");

    // R7: +2 wraps, even and odd
    tag = "R7";
    apply(0, 1, 1, 16'd1);
    while (e_count < 16'hFFF0) apply(1, 0, 0, 0);
    apply(0, 1, 1, 16'd0);
    while (e_count != 16'hFFFD) apply(1, 0, 0, 0);
    apply(1, 0, 0, 0);                    // -> FFFE
    apply(0, 1, 1, 16'd1);
    apply(1, 0, 0, 0);                    // FFFE -> 0000
    apply(0, 1, 1, 16'd0);
    while (e_count < 16'hFFF0) apply(1, 0, 0, 0);
    apply(0, 1, 1, 16'd1);
    while (e_count < 16'hFFF0) apply(1, 0, 0, 0);
    apply(0, 1, 1, 16'd0);
    while (e_count != 16'hFFFF) apply(1, 0, 0, 0);
    apply(0, 1, 1, 16'd1);
    apply(1, 0, 0, 0);                    // FFFF -> 0001

    // R5: random mix of codes, periods, modes and enables
    tag = "R5";
    for (int i = 0; i < 3000; i++) begin
      bit we  = ($urandom_range(0, 15) == 0);
      bit sel = $urandom_range(0, 1);
      logic [15:0] d;
      if (sel) d = 16'($urandom_range(0, 5));
      else d = {8'h00, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                6'($urandom_range(0, 3))};
      apply($urandom_range(0, 3) != 0, we, sel, d);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule